// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers interrupt requests from thirteen peripheral sources plus one non-maskable line and turns them into a 3-bit pending priority level for a processor. Every source has a latched request bit and its own enable bit. A master enable bit sits above all of them. Software changes request and enable bits through one write port. Each write either sets or clears the bits it names, so no read-modify-write is needed. Peripheral hardware can also set request bits directly.

The block also makes the processor's acceptance decision. When the processor strobes an acknowledge, the block compares the pending level with the 3-bit interrupt mask in the status word it receives. On the next cycle it returns an autovector table offset and an updated status word. That status word has the supervisor flag set and the mask raised to the level that was accepted. If nothing qualifies, the block returns the spurious-interrupt offset instead.

The write port uses a valid/ready handshake. `wr_ready` is always high, so the block never applies back-pressure. A write takes effect on every clock edge where `wr_valid` is high.

Top module: `irq_level_top`

## Requirements
- R1: Source bit positions map onto fixed levels. Bits 0 (serial transmit empty) and 1 (disk block done) are level 1. Bit 2 (software) is level 2. Bits 3, 4 and 5 (vertical blank, display coprocessor, blitter) are level 3. Bits 6 to 9 (audio channels 0 to 3) and bit 10 (disk sync) are level 4. Bit 11 (serial receive full) is level 5. Bit 12 (external/timer) is level 6. The `nmi_in` line is level 7.
- R2: `ipl` equals the highest level that has a request bit which is both set and enabled, or 7 while `nmi_in` is sampled high. It is 0 when no such request exists. It updates one clock after the request or enable register changes.
- R3: Enable bit 13 is the master enable. While it is 0, sources 0 to 12 do not contribute to `ipl`, but `nmi_in` still does.
- R4: A write with `wr_sel`=0 targets the request register and with `wr_sel`=1 targets the enable register. `wr_set`=1 sets every bit that is 1 in `wr_bits`. `wr_set`=0 clears those bits. All other bits keep their value. `wr_ready` is constant 1.
- R5: A bit high in `src_in` sets the matching request bit on that clock edge. It wins over a software clear of the same bit in the same cycle.
- R6: Request bits stay latched until software clears them. An acknowledge does not change them.
- R7: An `iack` strobe is answered one cycle later by a single-cycle `ack_valid`. When `ipl` is greater than `sr_in[10:8]`, the offset is 0x060 + 4*`ipl`.
- R8: Level 7 is accepted even when the mask equals 7, which gives offset 0x07C.
- R9: When `ipl` is 0, or is not above the mask and is below 7, the offset is 0x060 (spurious) and the mask field is returned unchanged.
- R10: `ack_sr` copies `sr_in` with bit 13 (supervisor) forced to 1. On acceptance, bits 10..8 are loaded with the accepted level.
- R11: After reset, requests, enables and `ipl` are 0 and `ack_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 13 | Hardware request pulses, one per source |
| nmi_in | input | 1 | Non-maskable request line (level 7) |
| wr_valid | input | 1 | Register write valid |
| wr_ready | output | 1 | Register write ready (always 1) |
| wr_sel | input | 1 | 0 = request register, 1 = enable register |
| wr_set | input | 1 | 1 = set named bits, 0 = clear named bits |
| wr_bits | input | 14 | Bits to change; bit 13 is the master enable |
| sr_in | input | 16 | Processor status word (mask in bits 10..8) |
| iack | input | 1 | Acknowledge strobe |
| ipl | output | 3 | Registered pending priority level |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vec | output | 8 | Autovector table offset |
| ack_sr | output | 16 | Updated status word |

## Verification
A wrong request or enable bit appears at `ipl` one clock after the faulty write, as the wrong level or a missing one. It can stay hidden while a higher level is pending. For that reason sources are driven alone as well as in combination. A fault in the acceptance path appears on the cycle after `iack`, as a wrong offset or a wrong mask in `ack_sr`. The cases that probe this are the mask boundaries: level equal to the mask, mask 7 with the non-maskable line, and nothing pending.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  localparam int NSRC   = 13;
  localparam int WBITS  = NSRC + 1;
  localparam int MASTER = NSRC;
  localparam int LVL_W  = 3;
  localparam int VEC_W  = 8;
  localparam int SR_W   = 16;
  localparam int SR_S   = 13;
  localparam int SR_MLO = 8;
  localparam logic [VEC_W-1:0] SPUR_VEC = 8'h60;

  function automatic logic [LVL_W-1:0] src_level(input int idx);
    if (idx < 2)       return 3'd1;
    else if (idx == 2) return 3'd2;
    else if (idx < 6)  return 3'd3;
    else if (idx < 11) return 3'd4;
    else if (idx == 11) return 3'd5;
    else               return 3'd6;
  endfunction
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_level_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic             wr_set,
  input  logic [WBITS-1:0] wr_bits,
  output logic [NSRC-1:0]  active
);
  logic [NSRC-1:0]  req_q;
  logic [WBITS-1:0] en_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_req
    logic hit;
    assign hit = wr_en && !wr_sel && wr_bits[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          req_q[i] <= 1'b0;
      else if (src_in[i])  req_q[i] <= 1'b1;
      else if (hit)        req_q[i] <= wr_set;
    end
  end

  for (genvar j = 0; j < WBITS; j++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             en_q[j] <= 1'b0;
      else if (wr_en && wr_sel && wr_bits[j]) en_q[j] <= wr_set;
    end
  end

  assign active = req_q & en_q[NSRC-1:0] & {NSRC{en_q[MASTER]}};
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_level_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  active,
  input  logic             nmi_in,
  output logic [LVL_W-1:0] ipl
);
  logic [LVL_W-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < NSRC; i++)
      if (active[i] && src_level(i) > best) best = src_level(i);
    if (nmi_in) best = 3'd7;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ipl <= '0;
    else        ipl <= best;
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_level_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack,
  input  logic [LVL_W-1:0] ipl,
  input  logic [SR_W-1:0]  sr_in,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vec,
  output logic [SR_W-1:0]  ack_sr
);
  logic [LVL_W-1:0] mask;
  logic             take;
  logic [SR_W-1:0]  sr_nxt;

  assign mask = sr_in[SR_MLO +: LVL_W];
  assign take = (ipl == 3'd7) || (ipl > mask);

  always_comb begin
    sr_nxt       = sr_in;
    sr_nxt[SR_S] = 1'b1;
    if (take) sr_nxt[SR_MLO +: LVL_W] = ipl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_vec   <= '0;
      ack_sr    <= '0;
    end else begin
      ack_valid <= iack;
      if (iack) begin
        ack_vec <= take ? (SPUR_VEC + {3'b0, ipl, 2'b00}) : SPUR_VEC;
        ack_sr  <= sr_nxt;
      end
    end
  end
endmodule

// File: rtl/irq_level_top.sv
module irq_level_top
  import irq_level_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [12:0]  src_in,
  input  logic         nmi_in,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic         wr_sel,
  input  logic         wr_set,
  input  logic [13:0]  wr_bits,
  input  logic [15:0]  sr_in,
  input  logic         iack,
  output logic [2:0]   ipl,
  output logic         ack_valid,
  output logic [7:0]   ack_vec,
  output logic [15:0]  ack_sr
);
  logic [NSRC-1:0] active;

  assign wr_ready = 1'b1;

  irq_src_regs u_regs (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .wr_en(wr_valid && wr_ready), .wr_sel(wr_sel), .wr_set(wr_set),
    .wr_bits(wr_bits), .active(active)
  );

  irq_level_enc u_enc (
    .clk(clk), .rst_n(rst_n), .active(active), .nmi_in(nmi_in), .ipl(ipl)
  );

  irq_accept u_acc (
    .clk(clk), .rst_n(rst_n), .iack(iack), .ipl(ipl), .sr_in(sr_in),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .ack_sr(ack_sr)
  );
endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nmi_in,
  input logic        iack,
  input logic [15:0] sr_in,
  input logic [2:0]  ipl,
  input logic        ack_valid,
  input logic [7:0]  ack_vec,
  input logic [15:0] ack_sr
);
  a_r7_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> ack_valid);
  a_r7_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |=> !ack_valid);
  a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_vec >= 8'h60 && ack_vec <= 8'h7C && ack_vec[1:0] == 2'b00));
  a_r8_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && ipl == 3'd7) |=> (ack_vec == 8'h7C));
  a_r10_super_set: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ack_sr[13]);
  a_r10_mask_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_vec != 8'h60) |-> (ack_sr[10:8] == 3'((ack_vec - 8'h60) >> 2)));
  a_r9_spur_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && ipl != 3'd7 && ipl <= sr_in[10:8]) |=> (ack_vec == 8'h60 && ack_sr[10:8] == $past(sr_in[10:8])));
  a_r2_seven_needs_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl == 3'd7) |-> $past(nmi_in));
endmodule

bind irq_level_top irq_level_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .iack(iack), .sr_in(sr_in),
  .ipl(ipl), .ack_valid(ack_valid), .ack_vec(ack_vec), .ack_sr(ack_sr)
);

// File: tb/tb_irq_level_top.sv
module tb_irq_level_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src_in = '0;
  logic        nmi_in = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_sel = 1'b0;
  logic        wr_set = 1'b0;
  logic [13:0] wr_bits = '0;
  logic [15:0] sr_in = '0;
  logic        iack = 1'b0;
  logic [2:0]  ipl;
  logic        ack_valid;
  logic [7:0]  ack_vec;
  logic [15:0] ack_sr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_level_top dut (.*);

  function automatic logic [2:0] lvl_of(input int i);
    case (i)
      0, 1: return 3'd1;
      2: return 3'd2;
      3, 4, 5: return 3'd3;
      6, 7, 8, 9, 10: return 3'd4;
      11: return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic set, input logic [13:0] bits);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_set = set; wr_bits = bits;
    @(negedge clk);
    wr_valid = 1'b0; wr_bits = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic ack(input logic [15:0] sr);
    @(negedge clk);
    iack = 1'b1; sr_in = sr;
    @(negedge clk);
    iack = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 ipl", {13'b0, ipl}, 16'd0);
    check("R11 ack_valid", {15'b0, ack_valid}, 16'd0);
    check("R4 wr_ready", {15'b0, wr_ready}, 16'd1);
  endtask

  task automatic t_levels();
    wr(1'b1, 1'b1, 14'h3FFF);
    for (int i = 0; i < 13; i++) begin
      wr(1'b0, 1'b1, 14'(1) << i);
      settle();
      check("R1 level of source", {13'b0, ipl}, {13'b0, lvl_of(i)});
      wr(1'b0, 1'b0, 14'(1) << i);
      settle();
    end
    check("R2 idle level", {13'b0, ipl}, 16'd0);
  endtask

  task automatic t_priority();
    wr(1'b0, 1'b1, 14'h0041);
    check("R2 one-cycle delay", {13'b0, ipl}, 16'd0);
    settle();
    check("R2 highest wins", {13'b0, ipl}, 16'd4);
    wr(1'b0, 1'b0, 14'h0040);
    settle();
    check("R4 clear leaves others", {13'b0, ipl}, 16'd1);
    wr(1'b0, 1'b0, 14'h0001);
    settle();
  endtask

  task automatic t_master();
    wr(1'b0, 1'b1, 14'h1000);
    wr(1'b1, 1'b0, 14'h2000);
    settle();
    check("R3 master off", {13'b0, ipl}, 16'd0);
    wr(1'b1, 1'b1, 14'h2000);
    settle();
    check("R3 master on", {13'b0, ipl}, 16'd6);
    wr(1'b1, 1'b0, 14'h1000);
    settle();
    check("R4 per-source enable clear", {13'b0, ipl}, 16'd0);
    wr(1'b1, 1'b1, 14'h1000);
    wr(1'b0, 1'b0, 14'h1000);
    settle();
  endtask

  task automatic t_hw_set();
    @(negedge clk);
    src_in = 13'h0008;
    wr_valid = 1'b1; wr_sel = 1'b0; wr_set = 1'b0; wr_bits = 14'h0008;
    @(negedge clk);
    src_in = '0; wr_valid = 1'b0; wr_bits = '0;
    settle();
    check("R5 hw set beats clear", {13'b0, ipl}, 16'd3);
  endtask

  task automatic t_accept();
    ack(16'h0200);
    check("R7 ack_valid", {15'b0, ack_valid}, 16'd1);
    check("R7 vector level 3", {8'b0, ack_vec}, 16'h006C);
    check("R10 status word", ack_sr, 16'h2300);
    settle();
    check("R7 single-cycle ack", {15'b0, ack_valid}, 16'd0);
    check("R6 request stays latched", {13'b0, ipl}, 16'd3);
    ack(16'h8300);
    check("R9 equal level spurious", {8'b0, ack_vec}, 16'h0060);
    check("R9 mask kept", ack_sr, 16'hA300);
    wr(1'b0, 1'b0, 14'h0008);
    settle();
  endtask

  task automatic t_nmi();
    @(negedge clk);
    nmi_in = 1'b1;
    settle();
    check("R2 nmi level", {13'b0, ipl}, 16'd7);
    ack(16'h0700);
    check("R8 nmi vector", {8'b0, ack_vec}, 16'h007C);
    check("R8 nmi status", ack_sr, 16'h2700);
    @(negedge clk);
    nmi_in = 1'b0;
    settle();
  endtask

  task automatic t_none();
    check("R2 nothing pending", {13'b0, ipl}, 16'd0);
    ack(16'h0000);
    check("R9 nothing pending vector", {8'b0, ack_vec}, 16'h0060);
    check("R10 spurious status", ack_sr, 16'h2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_priority();
    t_master();
    t_hw_set();
    t_accept();
    t_nmi();
    t_none();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule